// File: doc/BRIEF.md
# Tagged Reservation Stations with Result Broadcast

This block holds arithmetic instructions between issue and execution. It keeps a bank of tagged reservation stations: three for the add class (add, subtract) and two for the multiply class (multiply, divide). It also holds a small register file with a pending-producer table, and a single result bus that carries one result per cycle. An instruction issues into the lowest free station of its class. Each source operand is then either copied as a value or replaced by the tag of the station that will produce it. The destination register is renamed to the new station's tag. Because of this renaming, later writers of the same register do not wait for earlier readers or writers.

Waiting stations and renamed registers watch the result bus. They take a value when its tag matches the one they are waiting for. A station with both operands present starts a latency-counting execution stub. The stub then offers its result for broadcast. When several results are ready together, the lowest tag is granted the bus and the rest wait. A station is freed in the same cycle its result goes onto the bus. A registered read port shows each register's value and pending tag, so the renaming state can be seen from outside.

Top module: `rs_cdb_core`

## Requirements
- R1: After reset no station is busy and `iss_ready` is 1 for every op. `cdb_valid` is 0. Register i holds the value 3*i+1 with pending tag 0.
- R2: Op encoding is 0 add, 1 subtract, 2 multiply, 3 divide. Ops 0 and 1 use stations with tags 1..3, and ops 2 and 3 use tags 4..5. Issue always takes the lowest free tag of the class. `iss_ready` is 0 while every station of the class is busy. In that state an `iss_valid` has no effect.
- R3: At issue, a source with pending tag 0 is copied as a value. Otherwise the producer's tag is copied. The destination's pending tag becomes the new station's tag, and `rd_tag` shows this one cycle after the read address is presented.
- R4: When a bus result is present, every waiting operand and every register whose pending tag equals `cdb_tag` takes `cdb_value`, and its pending tag clears to 0.
- R5: An instruction whose operands are ready at issue has its result on the bus starting LAT+2 cycles after the issue edge. LAT is 2 for add and subtract, 10 for multiply and 40 for divide.
- R6: At most one result is broadcast per cycle. Among finished stations the lowest tag wins, and the others keep their results until they are granted.
- R7: A register's pending tag is cleared only by a broadcast carrying that same tag. A result from an older producer never overwrites a register that was renamed again afterwards.
- R8: A station becomes free on the edge that places its result on the bus. It can accept a new instruction on the next edge.
- R9: Stub results, all on 16 bits: add gives a+b, subtract gives a-b, multiply gives the low half of a*b, and divide gives a XOR b (first source a, second source b).
- R10: A station that takes its last operand from the bus starts execution one edge later. Its own broadcast starts LAT+3 cycles after the broadcast it consumed.
- R11: A source whose producer is on the bus in the issue cycle takes the bus value directly and is not left waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_op | input | 2 | Operation code (0 add, 1 sub, 2 mul, 3 div) |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | A station of the offered op's class is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | 3 | Tag of the station that produced the result |
| cdb_value | output | 16 | Broadcast result value |
| rd_addr | input | 3 | Register read address |
| rd_value | output | 16 | Registered value of the addressed register |
| rd_tag | output | 3 | Registered pending tag of the addressed register (0 = none) |

## Verification
A station that misses its wakeup shows up as a result that never appears on the bus, which is visible within one execution latency. A station that takes the wrong tag or a stale value puts a wrong `cdb_value` on the bus as soon as it finishes. A wrong pending-tag entry shows on `rd_tag` within one sweep of the read port. The same fault then corrupts the value of the register it guards when a broadcast arrives. A freeing or arbitration fault changes `iss_ready` or the order of tags on the bus in the very next cycle. For these reasons the port-level reference model is compared on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } rs_op_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_EXEC = 2'd1,
    PH_DONE = 2'd2
  } rs_phase_e;

  // multiply and divide share the multiply-class stations
  function automatic logic op_is_mul_class(input rs_op_e op);
    return op[1];
  endfunction

endpackage

// File: rtl/rs_arbiter.sv
// Lowest-index-first one-hot picker.
module rs_arbiter #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  assign grant = req & (~req + N'(1));
  assign any   = |req;
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TAGW    = 3,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 10,
  parameter int DIV_LAT = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  rs_op_e          alloc_op,
  input  logic [DW-1:0]   alloc_vj,
  input  logic [DW-1:0]   alloc_vk,
  input  logic [TAGW-1:0] alloc_qj,
  input  logic [TAGW-1:0] alloc_qk,
  input  logic            bus_valid,
  input  logic [TAGW-1:0] bus_tag,
  input  logic [DW-1:0]   bus_data,
  input  logic            grant,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   result
);
  localparam int MAXLAT = (DIV_LAT > MUL_LAT) ?
                          ((DIV_LAT > ADD_LAT) ? DIV_LAT : ADD_LAT) :
                          ((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT);
  localparam int CNTW = $clog2(MAXLAT + 1);

  rs_phase_e       phase;
  rs_op_e          op;
  logic [DW-1:0]   vj, vk;
  logic [TAGW-1:0] qj, qk;
  logic [CNTW-1:0] cnt;

  function automatic logic [CNTW-1:0] lat_of(input rs_op_e o);
    case (o)
      OP_MUL:  return CNTW'(MUL_LAT - 1);
      OP_DIV:  return CNTW'(DIV_LAT - 1);
      default: return CNTW'(ADD_LAT - 1);
    endcase
  endfunction

  function automatic logic [DW-1:0] calc(input rs_op_e o, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    case (o)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return p[DW-1:0];
      default: return a ^ b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= PH_WAIT;
      op     <= OP_ADD;
      vj     <= '0;
      vk     <= '0;
      qj     <= '0;
      qk     <= '0;
      cnt    <= '0;
      result <= '0;
    end else if (alloc) begin
      busy  <= 1'b1;
      phase <= PH_WAIT;
      op    <= alloc_op;
      vj    <= alloc_vj;
      vk    <= alloc_vk;
      qj    <= alloc_qj;
      qk    <= alloc_qk;
    end else if (busy) begin
      if (bus_valid && qj != '0 && qj == bus_tag) begin
        vj <= bus_data;
        qj <= '0;
      end
      if (bus_valid && qk != '0 && qk == bus_tag) begin
        vk <= bus_data;
        qk <= '0;
      end
      case (phase)
        PH_WAIT: if (qj == '0 && qk == '0) begin
          phase <= PH_EXEC;
          cnt   <= lat_of(op);
        end
        PH_EXEC: if (cnt == '0) begin
          phase  <= PH_DONE;
          result <= calc(op, vj, vk);
        end else begin
          cnt <= cnt - CNTW'(1);
        end
        PH_DONE: if (grant) begin
          busy  <= 1'b0;
          phase <= PH_WAIT;
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  assign done = busy && (phase == PH_DONE);

endmodule

// File: rtl/rs_regstat.sv
// Register values plus pending-producer tags; combinational source lookups,
// registered read port.
module rs_regstat #(
  parameter int DW    = 16,
  parameter int NREGS = 8,
  parameter int TAGW  = 3,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rename_en,
  input  logic [RW-1:0]   rename_reg,
  input  logic [TAGW-1:0] rename_tag,
  input  logic            bus_valid,
  input  logic [TAGW-1:0] bus_tag,
  input  logic [DW-1:0]   bus_data,
  input  logic [RW-1:0]   src1,
  input  logic [RW-1:0]   src2,
  output logic [DW-1:0]   s1_val,
  output logic [TAGW-1:0] s1_tag,
  output logic [DW-1:0]   s2_val,
  output logic [TAGW-1:0] s2_tag,
  input  logic [RW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_value,
  output logic [TAGW-1:0] rd_tag
);
  logic [DW-1:0]   val_q [NREGS];
  logic [TAGW-1:0] tag_q [NREGS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREGS; r++) begin
      if (rst) begin
        val_q[r] <= DW'(3 * r + 1);
        tag_q[r] <= '0;
      end else begin
        if (bus_valid && tag_q[r] != '0 && tag_q[r] == bus_tag) begin
          val_q[r] <= bus_data;
          tag_q[r] <= '0;
        end
        if (rename_en && rename_reg == RW'(r)) tag_q[r] <= rename_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_value <= '0;
      rd_tag   <= '0;
    end else begin
      rd_value <= val_q[rd_addr];
      rd_tag   <= tag_q[rd_addr];
    end
  end

  assign s1_val = val_q[src1];
  assign s1_tag = tag_q[src1];
  assign s2_val = val_q[src2];
  assign s2_tag = tag_q[src2];

endmodule

// File: rtl/rs_cdb_core.sv
module rs_cdb_core
  import rs_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NREGS   = 8,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 10,
  parameter int DIV_LAT = 40,
  localparam int NRS    = N_ADD + N_MUL,
  localparam int TAGW   = $clog2(NRS + 1),
  localparam int RW     = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic [1:0]      iss_op,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_src1,
  input  logic [RW-1:0]   iss_src2,
  output logic            iss_ready,
  output logic            cdb_valid,
  output logic [TAGW-1:0] cdb_tag,
  output logic [DW-1:0]   cdb_value,
  input  logic [RW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_value,
  output logic [TAGW-1:0] rd_tag
);
  rs_op_e          op_in;
  logic [NRS-1:0]  busy_v, done_v, grant_v, alloc_v;
  logic [DW-1:0]   res_a [NRS];
  logic [N_ADD-1:0] pick_add;
  logic [N_MUL-1:0] pick_mul;
  logic            any_add, any_mul, any_done, take;
  logic [TAGW-1:0] alloc_tag, win_tag;
  logic [DW-1:0]   win_val;
  logic [DW-1:0]   s1_val, s2_val, vj_in, vk_in;
  logic [TAGW-1:0] s1_tag, s2_tag, qj_in, qk_in;

  assign op_in = rs_op_e'(iss_op);

  // free-station pickers, one per class
  rs_arbiter #(.N(N_ADD)) u_pick_add (
    .req(~busy_v[N_ADD-1:0]), .grant(pick_add), .any(any_add));
  rs_arbiter #(.N(N_MUL)) u_pick_mul (
    .req(~busy_v[NRS-1:N_ADD]), .grant(pick_mul), .any(any_mul));

  assign iss_ready = op_is_mul_class(op_in) ? any_mul : any_add;
  assign take      = iss_valid && iss_ready;
  assign alloc_v   = !take ? '0 :
                     op_is_mul_class(op_in) ? {pick_mul, {N_ADD{1'b0}}}
                                            : {{N_MUL{1'b0}}, pick_add};

  always_comb begin
    alloc_tag = '0;
    for (int i = 0; i < NRS; i++)
      if (alloc_v[i]) alloc_tag = TAGW'(i + 1);
  end

  rs_regstat #(.DW(DW), .NREGS(NREGS), .TAGW(TAGW)) u_regs (
    .clk(clk), .rst(rst),
    .rename_en(take), .rename_reg(iss_dst), .rename_tag(alloc_tag),
    .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_value),
    .src1(iss_src1), .src2(iss_src2),
    .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
    .rd_addr(rd_addr), .rd_value(rd_value), .rd_tag(rd_tag));

  // operand capture at issue, with bypass from the bus in the same cycle
  always_comb begin
    vj_in = s1_val;
    qj_in = '0;
    if (s1_tag != '0) begin
      if (cdb_valid && s1_tag == cdb_tag) vj_in = cdb_value;
      else qj_in = s1_tag;
    end
    vk_in = s2_val;
    qk_in = '0;
    if (s2_tag != '0) begin
      if (cdb_valid && s2_tag == cdb_tag) vk_in = cdb_value;
      else qk_in = s2_tag;
    end
  end

  for (genvar g = 0; g < NRS; g++) begin : g_rs
    rs_station #(
      .DW(DW), .TAGW(TAGW),
      .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)
    ) u_rs (
      .clk(clk), .rst(rst),
      .alloc(alloc_v[g]), .alloc_op(op_in),
      .alloc_vj(vj_in), .alloc_vk(vk_in),
      .alloc_qj(qj_in), .alloc_qk(qk_in),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_value),
      .grant(grant_v[g]),
      .busy(busy_v[g]), .done(done_v[g]), .result(res_a[g]));
  end

  rs_arbiter #(.N(NRS)) u_bus_arb (.req(done_v), .grant(grant_v), .any(any_done));

  always_comb begin
    win_tag = '0;
    win_val = '0;
    for (int i = 0; i < NRS; i++)
      if (grant_v[i]) begin
        win_tag = TAGW'(i + 1);
        win_val = res_a[i];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cdb_valid <= 1'b0;
      cdb_tag   <= '0;
      cdb_value <= '0;
    end else begin
      cdb_valid <= any_done;
      cdb_tag   <= win_tag;
      cdb_value <= win_val;
    end
  end

endmodule

// File: rtl/rs_cdb_checks.sv
module rs_cdb_checks #(
  parameter int NRS  = 5,
  parameter int TAGW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [NRS-1:0]  alloc_v,
  input logic [NRS-1:0]  busy_v,
  input logic [NRS-1:0]  done_v,
  input logic [NRS-1:0]  grant_v,
  input logic            cdb_valid,
  input logic [TAGW-1:0] cdb_tag
);
  // R6: never more than one winner on the bus
  p_single_winner_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_v));

  // R6: a finished station is never left without any grant
  p_done_served_r6: assert property (@(posedge clk) disable iff (rst)
    (|done_v) |-> (|grant_v) && ((grant_v & ~done_v) == '0));

  // R6: a broadcast is always preceded by a finished station
  p_bus_from_done_r6: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> $past(|done_v));

  // R2: a stalled issue allocates nothing
  p_stall_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |-> (alloc_v == '0));

  // R2: allocation only into free stations, one at a time
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_v) && ((alloc_v & busy_v) == '0));

  // R8: the broadcasting station has already been released
  p_freed_on_bcast_r8: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> (cdb_tag != '0) && (busy_v[cdb_tag - 1'b1] == 1'b0));
endmodule

bind rs_cdb_core rs_cdb_checks #(.NRS(NRS), .TAGW(TAGW)) u_checks (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .alloc_v(alloc_v), .busy_v(busy_v), .done_v(done_v), .grant_v(grant_v),
  .cdb_valid(cdb_valid), .cdb_tag(cdb_tag));

// File: tb/rs_cdb_core_tb.sv
`timescale 1ns/1ps
module rs_cdb_core_tb;
  localparam int NRS = 5, NREG = 8, ALAT = 2, MLAT = 10, DLAT = 40;

  logic clk = 0, rst = 1;
  logic iss_valid = 0;
  logic [1:0] iss_op = 0;
  logic [2:0] iss_dst = 0, iss_src1 = 0, iss_src2 = 0, rd_addr = 0;
  logic iss_ready, cdb_valid;
  logic [2:0] cdb_tag, rd_tag;
  logic [15:0] cdb_value, rd_value;

  always #5 clk = ~clk;

  rs_cdb_core u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value), .rd_addr(rd_addr), .rd_value(rd_value), .rd_tag(rd_tag));

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  int m_busy[1:NRS], m_ph[1:NRS], m_op[1:NRS], m_vj[1:NRS], m_vk[1:NRS];
  int m_qj[1:NRS], m_qk[1:NRS], m_cnt[1:NRS], m_res[1:NRS];
  int m_val[0:NREG-1], m_stat[0:NREG-1];
  int m_cv = 0, m_ct = 0, m_cd = 0, m_rdv = 0, m_rdt = 0;
  bit m_took = 0;

  function automatic int lat(int op);
    return (op == 2) ? MLAT : (op == 3) ? DLAT : ALAT;
  endfunction

  function automatic int calc(int op, int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return int'(p & 64'hFFFF);
      default: return a ^ b;
    endcase
  endfunction

  function automatic bit m_ready(int op);
    int lo = (op >= 2) ? 4 : 1;
    int hi = (op >= 2) ? 5 : 3;
    for (int s = lo; s <= hi; s++) if (!m_busy[s]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int nb[1:NRS], nph[1:NRS], nop[1:NRS], nvj[1:NRS], nvk[1:NRS];
    int nqj[1:NRS], nqk[1:NRS], ncnt[1:NRS], nres[1:NRS];
    int nval[0:NREG-1], nstat[0:NREG-1];
    int g, lo, hi, sel, st;
    if (rst) begin
      for (int s = 1; s <= NRS; s++) begin
        m_busy[s] = 0; m_ph[s] = 0; m_qj[s] = 0; m_qk[s] = 0;
      end
      for (int r = 0; r < NREG; r++) begin m_val[r] = 3*r + 1; m_stat[r] = 0; end
      m_cv = 0; m_ct = 0; m_cd = 0; m_rdv = 0; m_rdt = 0; m_took = 0;
    end else begin
      nb = m_busy; nph = m_ph; nop = m_op; nvj = m_vj; nvk = m_vk;
      nqj = m_qj; nqk = m_qk; ncnt = m_cnt; nres = m_res;
      nval = m_val; nstat = m_stat;
      for (int s = 1; s <= NRS; s++) if (m_busy[s]) begin
        if (m_cv && m_qj[s] != 0 && m_qj[s] == m_ct) begin nvj[s] = m_cd; nqj[s] = 0; end
        if (m_cv && m_qk[s] != 0 && m_qk[s] == m_ct) begin nvk[s] = m_cd; nqk[s] = 0; end
        if (m_ph[s] == 0 && m_qj[s] == 0 && m_qk[s] == 0) begin
          nph[s] = 1; ncnt[s] = lat(m_op[s]) - 1;
        end else if (m_ph[s] == 1) begin
          if (m_cnt[s] == 0) begin nph[s] = 2; nres[s] = calc(m_op[s], m_vj[s], m_vk[s]); end
          else ncnt[s] = m_cnt[s] - 1;
        end
      end
      g = 0;
      for (int s = NRS; s >= 1; s--) if (m_busy[s] && m_ph[s] == 2) g = s;
      if (m_cv) for (int r = 0; r < NREG; r++)
        if (m_stat[r] != 0 && m_stat[r] == m_ct) begin nval[r] = m_cd; nstat[r] = 0; end
      m_took = 0;
      if (iss_valid) begin
        lo = (iss_op >= 2) ? 4 : 1; hi = (iss_op >= 2) ? 5 : 3; sel = 0;
        for (int s = hi; s >= lo; s--) if (!m_busy[s]) sel = s;
        if (sel != 0) begin
          m_took = 1; nb[sel] = 1; nph[sel] = 0; nop[sel] = iss_op;
          st = m_stat[iss_src1];
          if (st == 0) begin nvj[sel] = m_val[iss_src1]; nqj[sel] = 0; end
          else if (m_cv && st == m_ct) begin nvj[sel] = m_cd; nqj[sel] = 0; end
          else nqj[sel] = st;
          st = m_stat[iss_src2];
          if (st == 0) begin nvk[sel] = m_val[iss_src2]; nqk[sel] = 0; end
          else if (m_cv && st == m_ct) begin nvk[sel] = m_cd; nqk[sel] = 0; end
          else nqk[sel] = st;
          nstat[iss_dst] = sel;
        end
      end
      m_rdv = m_val[rd_addr]; m_rdt = m_stat[rd_addr];
      m_cv = (g != 0);
      if (g != 0) begin m_ct = g; m_cd = m_res[g]; nb[g] = 0; nph[g] = 0; end
      m_busy = nb; m_ph = nph; m_op = nop; m_vj = nvj; m_vk = nvk;
      m_qj = nqj; m_qk = nqk; m_cnt = ncnt; m_res = nres;
      m_val = nval; m_stat = nstat;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      rd_addr <= rd_addr + 3'd1;
      chk("cdb_valid", cdb_valid, m_cv);
      if (m_cv) begin
        chk("cdb_tag", cdb_tag, m_ct);
        chk("cdb_value", cdb_value, m_cd);
      end
      chk("rd_value", rd_value, m_rdv);
      chk("rd_tag", rd_tag, m_rdt);
    end
  end

  task automatic final_report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog %s actual=%0d expected=<150000", cur_req, cyc);
      final_report();
    end
  end

  // issue and hold until the model accepts; checks iss_ready every cycle
  task automatic issue(int op, int d, int a, int b);
    iss_valid = 1; iss_op = op[1:0]; iss_dst = d[2:0];
    iss_src1 = a[2:0]; iss_src2 = b[2:0];
    forever begin
      #1 chk("iss_ready", iss_ready, m_ready(op));
      @(negedge clk);
      if (m_took) break;
    end
    iss_valid = 0;
  endtask

  task automatic drain();
    bit idle;
    do begin
      @(negedge clk);
      idle = !m_cv;
      for (int s = 1; s <= NRS; s++) if (m_busy[s]) idle = 0;
    end while (!idle);
    repeat (10) @(negedge clk);
  endtask

  // cycles from the issue edge to the first broadcast
  task automatic measure_lat(int op, int expd);
    int n = 0;
    issue(op, 7, 1, 2);
    while (!cdb_valid) begin @(negedge clk); n++; end
    chk("issue-to-bus latency", n, expd);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: state right after reset
    cur_req = "R1";
    chk("cdb_valid after reset", cdb_valid, 0);
    for (int o = 0; o < 4; o++) begin
      iss_op = o[1:0];
      #1 chk("iss_ready after reset", iss_ready, 1);
    end
    repeat (12) @(negedge clk);

    cur_req = "R9";
    issue(0, 3, 1, 2); issue(1, 4, 1, 7); issue(2, 5, 2, 3); issue(3, 6, 7, 2);
    drain();

    cur_req = "R5";
    measure_lat(0, ALAT + 2);
    measure_lat(2, MLAT + 2);
    measure_lat(3, DLAT + 2);

    // R3 and R4: dependent chain, tags on rd_tag, values by wakeup
    cur_req = "R3";
    issue(2, 1, 2, 3); issue(0, 2, 1, 1); issue(1, 4, 2, 5);
    cur_req = "R4";
    drain();

    // R10: consumer broadcasts LAT+3 cycles after its producer
    cur_req = "R10";
    begin
      int n = 0;
      issue(2, 1, 3, 4); issue(0, 2, 1, 0);
      while (!cdb_valid) @(negedge clk);
      do begin @(negedge clk); n++; end while (!cdb_valid);
      chk("wakeup-to-bus gap", n, ALAT + 3);
    end
    drain();

    // R7: a long older write must not clobber a newer rename
    cur_req = "R7";
    issue(3, 6, 1, 2); issue(0, 6, 3, 3); issue(0, 5, 6, 6);
    drain();

    // R6: three adds waiting on one result finish together
    cur_req = "R6";
    issue(2, 1, 2, 2); issue(0, 2, 1, 3); issue(0, 3, 1, 4); issue(1, 4, 1, 5);
    drain();

    // R2 and R8: fill the add class behind a divide; fourth add stalls
    cur_req = "R2";
    issue(3, 7, 1, 1);
    issue(0, 1, 7, 2); issue(0, 2, 7, 3); issue(1, 3, 7, 4);
    cur_req = "R8";
    issue(0, 4, 5, 5);
    issue(2, 5, 4, 4); issue(2, 6, 4, 1); issue(3, 0, 6, 6);
    drain();

    // R11: dense random stream exercises same-cycle bypass at issue
    cur_req = "R11";
    for (int k = 0; k < 400; k++) begin
      int op, gap;
      op = $urandom_range(0, 9);
      op = (op < 6) ? (op & 1) : (op < 9) ? 2 : 3;
      issue(op, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
    end
    drain();

    final_report();
  end
endmodule